// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block puts the command interface of a classic parallel NOR flash in front of a small on-chip word array. Every accepted bus write is read as a command cycle. Bus reads return one of four things: array contents, the status byte, identifier bytes, or query bytes. Which one depends on the mode that the last command latched.

Single-word program, sector erase, status clear, lock/unlock acknowledge, status read, identifier read, query and return to array reading are all decoded. Multi-cycle commands track their second cycle. A confirm byte completes the command. A reset byte or any unexpected byte sends the block back to array reading.

A read-only strap turns program and erase into error reports in the status byte. An erase fills its sector one word per clock. While the fill runs, the bus is held off through a ready output.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte is 0x80, no command cycle is pending, and reads return array data.
- R2: A first-cycle write with low byte 0x00, 0xF0 or 0xFF returns the block to array reading.
- R3: A first-cycle 0x40 or 0x10 arms a program. The next write stores its full data word at its address, sets status bit 7, leaves status mode selected, and makes the following write a first-cycle command.
- R4: A first-cycle 0x20 sets status bit 7 and fills the addressed sector with all ones. The sector base is the address with its low SECT_W bits cleared. A second-cycle 0xD0 confirms and keeps status mode.
- R5: In the erase second cycle, 0xFF, or any value other than 0xD0, returns the block to array reading.
- R6: With the read-only strap high, the array is never written. A program sets status bits 7 and 4, and an erase sets status bits 7 and 5.
- R7: A first-cycle 0x50 clears the whole status byte and returns to array reading. A first-cycle 0x70 selects status reading with no cycle pending.
- R8: A first-cycle 0x60 waits for a second cycle. 0xD0 or 0x01 sets status bit 7 and keeps status mode. Any other value returns to array reading.
- R9: A read in status mode returns the status byte in every 8-bit lane. Read data appears with rd_valid one clock after the read is accepted.
- R10: After a first-cycle 0x90, word address 0 reads MFR_ID and word address 1 reads DEV_ID, replicated into every lane. Other addresses read 0.
- R11: After a first-cycle 0x98, word addresses 0x10, 0x11 and 0x12 read 0x51, 0x52 and 0x59. Address 0x27 reads log2 of the array size in bytes. Other addresses read 0. All values are replicated per lane. Writes other than 0xFF keep query mode, and 0xFF leaves it.
- R12: Only bits 7:0 of a command write are decoded. An unrecognised first-cycle command returns to array reading.
- R13: During an erase fill, req_ready is low for exactly 2**SECT_W cycles, and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ro_strap | input | 1 | Read-only strap, blocks all array writes |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8*LANES | Write data (command in bits 7:0) |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8*LANES | Read data |

## Verification
The assertions check several rules on every cycle: status bit 7 after a program data cycle, the zero status after a clear, the fill length and its start, the absence of array writes under the read-only strap, and the lane replication and one-cycle latency of status reads. Only the bench scenarios can show the mode each command leaves behind. They also show the sector alignment and fill pattern seen through later array reads, the identifier and query values, and that error and abort bytes leave the array untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam logic [7:0] C_NOP   = 8'h00;
   localparam logic [7:0] C_PROGB = 8'h10;
   localparam logic [7:0] C_ERASE = 8'h20;
   localparam logic [7:0] C_PROG  = 8'h40;
   localparam logic [7:0] C_CLRSR = 8'h50;
   localparam logic [7:0] C_LOCK  = 8'h60;
   localparam logic [7:0] C_RDSR  = 8'h70;
   localparam logic [7:0] C_IDENT = 8'h90;
   localparam logic [7:0] C_QUERY = 8'h98;
   localparam logic [7:0] C_CONF  = 8'hD0;
   localparam logic [7:0] C_ULK1  = 8'h01;
   localparam logic [7:0] C_ALT   = 8'hF0;
   localparam logic [7:0] C_ARRAY = 8'hFF;

   typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_IDENT, M_QUERY} rd_mode_e;
   typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_LOCK, S_QUERY} seq_state_e;

   function automatic logic [7:0] query_byte(input logic [7:0] off, input logic [7:0] size_log2);
      case (off)
         8'h10:   return 8'h51;
         8'h11:   return 8'h52;
         8'h12:   return 8'h59;
         8'h27:   return size_log2;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/flash_word_ram.sv
module flash_word_ram #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ro_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int WORDS = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      if (re_i) rdata_o <= mem[raddr_i];
   end

   // R6: the strap keeps every array write away
   p_ro_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n) ro_i |-> !we_i)
      else $error("array written with read-only strap");
endmodule

// File: rtl/flash_erase_fill.sv
module flash_erase_fill #(
   parameter int ADDR_W = 6,
   parameter int SECT_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [DATA_W-1:0] wdata_o
);
   localparam int BASE_W = ADDR_W - SECT_W;
   localparam logic [SECT_W-1:0] LAST = '1;

   logic [BASE_W-1:0] base_q;
   logic [SECT_W-1:0] cnt_q;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         base_q <= addr_i[ADDR_W-1:SECT_W];
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) busy_q <= 1'b0;
      end
   end

   assign busy_o  = busy_q;
   assign waddr_o = {base_q, cnt_q};
   assign wdata_o = '1;

   // R13: a started fill is busy on the next cycle
   p_fill_start_r13: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> busy_q)
      else $error("fill did not start");
   // R4: the fill stops after the last word of the sector
   p_fill_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == LAST && !start_i) |=> !busy_q)
      else $error("fill overran sector");
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [7:0]        cmd_i,
   input  logic              ro_i,
   output rd_mode_e          mode_o,
   output logic [7:0]        status_o,
   output logic              prog_we_o,
   output logic              erase_start_o
);
   seq_state_e state_q;
   rd_mode_e   mode_q;
   logic [7:0] status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         mode_q   <= M_ARRAY;
         status_q <= 8'h80;
      end else if (wr_i) begin
         case (state_q)
            S_IDLE: begin
               case (cmd_i)
                  C_NOP, C_ALT, C_ARRAY: mode_q <= M_ARRAY;
                  C_PROG, C_PROGB: begin
                     state_q <= S_PROG;
                     mode_q  <= M_STATUS;
                  end
                  C_ERASE: begin
                     state_q     <= S_ERASE;
                     mode_q      <= M_STATUS;
                     status_q[7] <= 1'b1;
                     if (ro_i) status_q[5] <= 1'b1;
                  end
                  C_CLRSR: begin
                     status_q <= 8'h00;
                     mode_q   <= M_ARRAY;
                  end
                  C_LOCK: begin
                     state_q <= S_LOCK;
                     mode_q  <= M_STATUS;
                  end
                  C_RDSR:  mode_q <= M_STATUS;
                  C_IDENT: mode_q <= M_IDENT;
                  C_QUERY: begin
                     state_q <= S_QUERY;
                     mode_q  <= M_QUERY;
                  end
                  default: mode_q <= M_ARRAY;
               endcase
            end
            S_PROG: begin
               status_q[7] <= 1'b1;
               if (ro_i) status_q[4] <= 1'b1;
               state_q <= S_IDLE;
            end
            S_ERASE: begin
               state_q <= S_IDLE;
               if (cmd_i == C_CONF) status_q[7] <= 1'b1;
               else                 mode_q <= M_ARRAY;
            end
            S_LOCK: begin
               state_q <= S_IDLE;
               if (cmd_i == C_CONF || cmd_i == C_ULK1) status_q[7] <= 1'b1;
               else                                    mode_q <= M_ARRAY;
            end
            S_QUERY: begin
               if (cmd_i == C_ARRAY) begin
                  state_q <= S_IDLE;
                  mode_q  <= M_ARRAY;
               end
            end
            default: begin
               state_q <= S_IDLE;
               mode_q  <= M_ARRAY;
            end
         endcase
      end
   end

   assign mode_o        = mode_q;
   assign status_o      = status_q;
   assign prog_we_o     = wr_i && state_q == S_PROG && !ro_i;
   assign erase_start_o = wr_i && state_q == S_IDLE && cmd_i == C_ERASE && !ro_i;

   // R3: data cycle of a program sets bit 7 and ends the sequence
   p_prog_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && state_q == S_PROG) |=> (status_q[7] && state_q == S_IDLE))
      else $error("program cycle did not complete");
   // R7: clear status empties the status byte
   p_clear_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && state_q == S_IDLE && cmd_i == C_CLRSR) |=> (status_q == 8'h00 && mode_q == M_ARRAY))
      else $error("status clear failed");
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_seq_pkg::*;
#(
   parameter int         ADDR_W = 6,
   parameter int         SECT_W = 3,
   parameter int         LANES  = 2,
   parameter logic [7:0] MFR_ID = 8'h89,
   parameter logic [7:0] DEV_ID = 8'h18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ro_strap,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [8*LANES-1:0]   req_wdata,
   output logic                 req_ready,
   output logic                 rd_valid,
   output logic [8*LANES-1:0]   rd_data
);
   localparam int         DATA_W    = 8 * LANES;
   localparam logic [7:0] SIZE_LOG2 = 8'(ADDR_W + $clog2(LANES));

   generate
      if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
         $error("SECT_W must lie in 1..ADDR_W-1");
      end
      if (LANES < 1 || LANES > 8) begin : g_bad_lanes
         $error("LANES must lie in 1..8");
      end
   endgenerate

   rd_mode_e          mode;
   logic [7:0]        status;
   logic              prog_we, erase_start, fill_busy;
   logic [ADDR_W-1:0] fill_addr;
   logic [DATA_W-1:0] fill_data, ram_q;
   logic              wr_acc, rd_acc;

   assign req_ready = !fill_busy;
   assign wr_acc    = req_valid && req_ready && req_write;
   assign rd_acc    = req_valid && req_ready && !req_write;

   flash_cmd_fsm #(.ADDR_W(ADDR_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_acc), .cmd_i(req_wdata[7:0]), .ro_i(ro_strap),
      .mode_o(mode), .status_o(status), .prog_we_o(prog_we), .erase_start_o(erase_start)
   );

   flash_erase_fill #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) fill_i (
      .clk(clk), .rst_n(rst_n), .start_i(erase_start), .addr_i(req_addr),
      .busy_o(fill_busy), .waddr_o(fill_addr), .wdata_o(fill_data)
   );

   flash_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
      .clk(clk), .rst_n(rst_n), .ro_i(ro_strap),
      .we_i(fill_busy || prog_we),
      .waddr_i(fill_busy ? fill_addr : req_addr),
      .wdata_i(fill_busy ? fill_data : req_wdata),
      .re_i(rd_acc), .raddr_i(req_addr), .rdata_o(ram_q)
   );

   // per-lane byte chosen by the latched read mode
   logic [7:0] aux_byte;
   logic [7:0] off8;
   assign off8 = 8'(req_addr);
   always_comb begin
      case (mode)
         M_STATUS: aux_byte = status;
         M_IDENT:  aux_byte = (off8 == 8'd0) ? MFR_ID : (off8 == 8'd1) ? DEV_ID : 8'h00;
         M_QUERY:  aux_byte = query_byte(off8, SIZE_LOG2);
         default:  aux_byte = 8'h00;
      endcase
   end

   logic [DATA_W-1:0] aux_word;
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign aux_word[8*g +: 8] = aux_byte;
      end
   endgenerate

   logic              rd_valid_q, rd_arr_q;
   logic [DATA_W-1:0] aux_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_arr_q   <= 1'b1;
         aux_q      <= '0;
      end else begin
         rd_valid_q <= rd_acc;
         if (rd_acc) begin
            rd_arr_q <= (mode == M_ARRAY);
            aux_q    <= aux_word;
         end
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_arr_q ? ram_q : aux_q;

   // R9: accepted read answers one cycle later
   p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n) rd_acc |=> rd_valid)
      else $error("read not answered");
   // R9: status reads fill every lane with the same byte
   p_status_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && mode == M_STATUS) |=> rd_data == {LANES{rd_data[7:0]}})
      else $error("status lanes differ");
endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
   localparam int ADDR_W = 6;
   localparam int LANES  = 2;
   localparam int NV     = 58;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ro_strap = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [15:0]       req_wdata = '0;
   logic              req_ready, rd_valid;
   logic [15:0]       rd_data;
   int                checks = 0;
   int                errors = 0;

   always #2.5 clk = ~clk;

   flash_cmd_seq #(.ADDR_W(ADDR_W), .SECT_W(3), .LANES(LANES)) dut_i (
      .clk(clk), .rst_n(rst_n), .ro_strap(ro_strap), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // {write, requirement, word address, data or expected read value}
   localparam logic [28:0] VEC [NV] = '{
      {1'b1, 4'd7,  8'h00, 16'h0070},   // R7 status mode
      {1'b0, 4'd1,  8'h00, 16'h8080},   // R1 reset status, R9 lanes
      {1'b1, 4'd4,  8'h00, 16'h0020},   // R4 erase sector 0
      {1'b1, 4'd4,  8'h00, 16'h00D0},
      {1'b0, 4'd4,  8'h00, 16'h8080},
      {1'b1, 4'd2,  8'h00, 16'h00FF},
      {1'b0, 4'd4,  8'h05, 16'hFFFF},
      {1'b0, 4'd4,  8'h07, 16'hFFFF},
      {1'b1, 4'd3,  8'h03, 16'h0040},   // R3 program
      {1'b1, 4'd3,  8'h03, 16'h1234},
      {1'b0, 4'd3,  8'h03, 16'h8080},
      {1'b1, 4'd2,  8'h00, 16'h00FF},
      {1'b0, 4'd3,  8'h03, 16'h1234},
      {1'b0, 4'd3,  8'h02, 16'hFFFF},
      {1'b1, 4'd4,  8'h09, 16'h0020},   // R4 unaligned sector address
      {1'b1, 4'd5,  8'h09, 16'h00FF},   // R5 abort byte
      {1'b0, 4'd4,  8'h08, 16'hFFFF},
      {1'b0, 4'd4,  8'h0F, 16'hFFFF},
      {1'b0, 4'd3,  8'h03, 16'h1234},
      {1'b1, 4'd3,  8'h0A, 16'h0010},   // R3 alternate program code
      {1'b1, 4'd3,  8'h0A, 16'hA55A},
      {1'b1, 4'd2,  8'h00, 16'h00FF},
      {1'b0, 4'd3,  8'h0A, 16'hA55A},
      {1'b1, 4'd12, 8'h00, 16'h7F70},   // R12 upper lane ignored
      {1'b0, 4'd12, 8'h00, 16'h8080},
      {1'b1, 4'd12, 8'h00, 16'h0033},   // R12 unknown code
      {1'b0, 4'd12, 8'h03, 16'h1234},
      {1'b1, 4'd10, 8'h00, 16'h0090},   // R10 identifier
      {1'b0, 4'd10, 8'h00, 16'h8989},
      {1'b0, 4'd10, 8'h01, 16'h1818},
      {1'b0, 4'd10, 8'h02, 16'h0000},
      {1'b1, 4'd2,  8'h00, 16'h00FF},
      {1'b1, 4'd11, 8'h00, 16'h0098},   // R11 query
      {1'b0, 4'd11, 8'h10, 16'h5151},
      {1'b0, 4'd11, 8'h11, 16'h5252},
      {1'b0, 4'd11, 8'h12, 16'h5959},
      {1'b0, 4'd11, 8'h27, 16'h0707},
      {1'b0, 4'd11, 8'h13, 16'h0000},
      {1'b1, 4'd11, 8'h00, 16'h0050},
      {1'b0, 4'd11, 8'h10, 16'h5151},
      {1'b1, 4'd11, 8'h00, 16'h00FF},
      {1'b0, 4'd11, 8'h03, 16'h1234},
      {1'b1, 4'd8,  8'h00, 16'h0060},   // R8 lock acknowledge
      {1'b1, 4'd8,  8'h00, 16'h0001},
      {1'b0, 4'd8,  8'h00, 16'h8080},
      {1'b1, 4'd8,  8'h00, 16'h0060},
      {1'b1, 4'd8,  8'h00, 16'h0077},
      {1'b0, 4'd8,  8'h03, 16'h1234},
      {1'b1, 4'd7,  8'h00, 16'h0050},   // R7 clear
      {1'b0, 4'd7,  8'h03, 16'h1234},
      {1'b1, 4'd7,  8'h00, 16'h0070},
      {1'b0, 4'd7,  8'h00, 16'h0000},
      {1'b1, 4'd5,  8'h08, 16'h0020},   // R5 erase then bad byte
      {1'b1, 4'd5,  8'h08, 16'h0012},
      {1'b0, 4'd5,  8'h0A, 16'hFFFF},
      {1'b1, 4'd2,  8'h00, 16'h00F0},   // R2 alternate reset code
      {1'b0, 4'd2,  8'h03, 16'h1234},
      {1'b1, 4'd2,  8'h00, 16'h0000}
   };

   task automatic wait_ready();
      while (!req_ready) @(negedge clk);
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
      wait_ready();
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_check(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input int rq);
      wait_ready();
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if (!rd_valid || rd_data !== exp) begin
         errors++;
         $display("FAIL R%0d addr %0h: got %h valid %b, expected %h", rq, a, rd_data, rd_valid, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int low_cycles;
      do_reset();
      // R1: reset reads array data; read of sector 0 after table erase checked below
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][28]) bus_write(VEC[i][ADDR_W+15:16], VEC[i][15:0]);
         else            bus_check(VEC[i][ADDR_W+15:16], VEC[i][15:0], int'(VEC[i][27:24]));
      end
      bus_check(6'd3, 16'h1234, 2);   // R2 code 0x00 gives array reading

      // R13: fill holds ready low for one sector of clocks
      req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd20; req_wdata = 16'h0020;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      low_cycles = 0;
      while (!req_ready && low_cycles < 50) begin
         low_cycles++;
         @(negedge clk);
      end
      checks++;
      if (low_cycles != 8) begin
         errors++;
         $display("FAIL R13 busy cycles: got %0d, expected 8", low_cycles);
      end
      bus_write(6'd0, 16'h00FF);
      bus_check(6'd23, 16'hFFFF, 13);  // R13 sector 2 filled
      bus_check(6'd16, 16'hFFFF, 4);   // R4 sector base

      // R6: strap blocks program and erase, reports bits 4 and 5
      ro_strap = 1'b1;
      bus_write(6'd0, 16'h0050);
      bus_write(6'd3, 16'h0040);
      bus_write(6'd3, 16'h5555);
      bus_check(6'd3, 16'h9090, 6);
      bus_write(6'd0, 16'h0020);
      checks++;
      if (!req_ready) begin
         errors++;
         $display("FAIL R6 ready: got 0, expected 1");
      end
      bus_write(6'd0, 16'h00D0);
      bus_check(6'd0, 16'hB0B0, 6);
      bus_write(6'd0, 16'h00FF);
      bus_check(6'd3, 16'h1234, 6);
      ro_strap = 1'b0;

      // R1: reset restores status 0x80 and array reading
      do_reset();
      bus_check(6'd3, 16'h1234, 1);
      bus_write(6'd0, 16'h0070);
      bus_check(6'd0, 16'h8080, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule